// File: doc/BRIEF.md
# Vector-Driven FIFO Entry Slice Unpacker

The block takes 32-bit transmit FIFO entries and breaks each one into short bit slices for a serial shifter. Each slice holds one to eight bits. Four 10-bit packing descriptors set how an entry is cut. Each descriptor gives a start bit, a direction, a length and a stop flag. The descriptors are held in two 32-bit configuration words. Software writes them once for a given word size and packing density, and the unpacker then replays the same pattern on every entry.

Entries arrive on a valid/ready stream. Slices leave on a second valid/ready stream, one per clock while the consumer is ready. Each slice carries its bits in transmission order, its bit count, its direction and an end-of-entry marker. The descriptors may change only while the unpacker is idle. The next entry is taken in the same cycle that the final slice of the current entry is consumed, so a busy stream has no bubble between entries.

Top module: `fifo_slice_unpacker`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. Whenever no slice is pending, in_ready is 1.
- R2: Descriptor 0 is taken from cfg_lo[9:0] and descriptor 1 from cfg_lo[19:10]. Descriptors 2 and 3 sit at the same positions in cfg_hi. Inside a descriptor, the start bit is in [9:5], the direction in [4], the length minus one in [3:1] and the stop flag in [0].
- R3: With direction 0, out_bits[k] equals in_word[start+k] for k from 0 to the length minus one. A position above 31 reads as 0.
- R4: With direction 1, out_bits[k] equals in_word[start-k]. A position below 0 reads as 0. In both directions, out_bits bits at index out_cnt and above are 0.
- R5: out_cnt equals the length field plus one, in the range 1 to 8. out_dir equals the direction bit of the descriptor that produced the slice.
- R6: The descriptors of an entry are applied in order 0, 1, 2, 3, one slice per out_valid && out_ready handshake. While out_ready is low, the pending slice and all its fields hold stable.
- R7: An entry ends at the first descriptor whose stop flag is 1, and out_last is 1 on that slice. Later descriptors are ignored, so no slice is produced from them.
- R8: If none of the four descriptors has its stop flag set, descriptor 3 ends the entry. An entry therefore never yields more than four slices.
- R9: in_ready is 1 during a pending slice only when that slice is the last of its entry and out_ready is 1. The next entry is then accepted in that same cycle, and its first slice is offered in the following cycle.
- R10: Three standard layouts give the expected slices: seven-bit words four per entry MSB first (starts 6, 14, 22, 30, length field 6); fifteen-bit words two per entry LSB first (starts 0, 8, 16, 24, length fields 7, 6, 7, 6); one 23-bit word MSB first (starts 22, 14, 6, length fields 7, 7, 6, stop on descriptor 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_lo | input | 32 | Descriptors 0 and 1 |
| cfg_hi | input | 32 | Descriptors 2 and 3 |
| in_valid | input | 1 | FIFO entry offered |
| in_ready | output | 1 | FIFO entry accepted when valid |
| in_word | input | 32 | FIFO entry |
| out_valid | output | 1 | Slice pending |
| out_ready | input | 1 | Consumer takes the slice |
| out_bits | output | 8 | Slice bits, index 0 sent first |
| out_cnt | output | 4 | Number of valid bits, 1 to 8 |
| out_dir | output | 1 | 1 for MSB first, 0 for LSB first |
| out_last | output | 1 | Final slice of the entry |

## Verification
Two events can land in the same clock: the handoff of an entry's final slice and the acceptance of the next FIFO entry. The bench triggers this by holding in_valid high over long back-to-back runs, with out_ready either held high or toggled at random. The reference model then requires in_ready to rise exactly when the single remaining expected slice is taken. The first slice of the new entry must follow in the very next cycle, and no slice may be lost or duplicated.

// File: rtl/slice_unpack_pkg.sv
package slice_unpack_pkg;

   localparam int DESC_W    = 10;
   localparam int START_W   = 5;
   localparam int LEN_W     = 3;
   localparam int MAX_SLICE = 1 << LEN_W;

   typedef struct packed {
      logic [START_W-1:0] start;
      logic               dir;
      logic [LEN_W-1:0]   len_m1;
      logic               stop;
   } pack_desc_t;

   function automatic pack_desc_t desc_from_bits(input logic [DESC_W-1:0] raw);
      pack_desc_t d;
      d.start  = raw[9:5];
      d.dir    = raw[4];
      d.len_m1 = raw[3:1];
      d.stop   = raw[0];
      return d;
   endfunction

endpackage

// File: rtl/pack_desc_decode.sv
module pack_desc_decode
   import slice_unpack_pkg::*;
#(
   parameter int NUM_DESC     = 4,
   parameter int CFG_W        = 32,
   parameter int DESC_PER_REG = 2,
   localparam int NUM_REG     = (NUM_DESC + DESC_PER_REG - 1) / DESC_PER_REG
) (
   input  logic [NUM_REG*CFG_W-1:0] cfg_flat,
   output pack_desc_t               desc [NUM_DESC]
);

   if (DESC_PER_REG * DESC_W > CFG_W) begin : g_bad_fit
      $error("descriptors do not fit in a configuration register");
   end

   for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
      localparam int REG_IDX = i / DESC_PER_REG;
      localparam int SLOT    = i % DESC_PER_REG;
      localparam int LSB     = REG_IDX * CFG_W + SLOT * DESC_W;
      assign desc[i] = desc_from_bits(cfg_flat[LSB +: DESC_W]);
   end

endmodule

// File: rtl/slice_extract.sv
module slice_extract
   import slice_unpack_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int SLICE_W  = MAX_SLICE,
   localparam int IDX_W   = $clog2(WORD_W),
   localparam int CNT_W   = $clog2(SLICE_W + 1)
) (
   input  logic [WORD_W-1:0]  word,
   input  pack_desc_t         desc,
   output logic [SLICE_W-1:0] bits,
   output logic [CNT_W-1:0]   cnt
);

   for (genvar k = 0; k < SLICE_W; k++) begin : g_bit
      int   pos;
      logic in_len;
      always_comb begin
         pos    = desc.dir ? int'(desc.start) - k : int'(desc.start) + k;
         in_len = (k <= int'(desc.len_m1));
         if (in_len && pos >= 0 && pos < WORD_W)
            bits[k] = word[pos[IDX_W-1:0]];
         else
            bits[k] = 1'b0;
      end
   end

   assign cnt = CNT_W'(desc.len_m1) + CNT_W'(1);

endmodule

// File: rtl/slice_sequencer.sv
module slice_sequencer
   import slice_unpack_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int NUM_DESC = 4,
   localparam int SEL_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pack_desc_t        desc [NUM_DESC],
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] held_word,
   output pack_desc_t        cur_desc,
   output logic              cur_last
);

   logic              busy_q;
   logic [SEL_W-1:0]  sel_q;
   logic [WORD_W-1:0] word_q;
   logic              take;
   logic              load;

   always_comb begin
      cur_desc = desc[0];
      for (int i = 0; i < NUM_DESC; i++)
         if (sel_q == SEL_W'(i)) cur_desc = desc[i];
   end

   assign cur_last  = cur_desc.stop || (sel_q == SEL_W'(NUM_DESC - 1));
   assign take      = busy_q && out_ready;
   assign in_ready  = !busy_q || (take && cur_last);
   assign load      = in_valid && in_ready;
   assign out_valid = busy_q;
   assign held_word = word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sel_q  <= '0;
         word_q <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         sel_q  <= '0;
         word_q <= in_word;
      end else if (take) begin
         if (cur_last) begin
            busy_q <= 1'b0;
            sel_q  <= '0;
         end else begin
            sel_q <= sel_q + SEL_W'(1);
         end
      end
   end

endmodule

// File: rtl/fifo_slice_unpacker.sv
module fifo_slice_unpacker
   import slice_unpack_pkg::*;
#(
   parameter int WORD_W       = 32,
   parameter int CFG_W        = 32,
   parameter int NUM_DESC     = 4,
   parameter int DESC_PER_REG = 2,
   parameter int SLICE_W      = MAX_SLICE,
   localparam int CNT_W       = $clog2(SLICE_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CFG_W-1:0]   cfg_lo,
   input  logic [CFG_W-1:0]   cfg_hi,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [WORD_W-1:0]  in_word,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [SLICE_W-1:0] out_bits,
   output logic [CNT_W-1:0]   out_cnt,
   output logic               out_dir,
   output logic               out_last
);

   if (WORD_W > (1 << START_W)) begin : g_bad_word
      $error("start field cannot address the whole word");
   end
   if (SLICE_W != MAX_SLICE) begin : g_bad_slice
      $error("slice width must match the length field range");
   end
   if (NUM_DESC != 2 * DESC_PER_REG) begin : g_bad_count
      $error("descriptors must fill exactly two configuration registers");
   end

   pack_desc_t        desc [NUM_DESC];
   pack_desc_t        cur_desc;
   logic [WORD_W-1:0] held_word;
   logic              cur_last;

   pack_desc_decode #(
      .NUM_DESC     (NUM_DESC),
      .CFG_W        (CFG_W),
      .DESC_PER_REG (DESC_PER_REG)
   ) u_decode (
      .cfg_flat ({cfg_hi, cfg_lo}),
      .desc     (desc)
   );

   slice_sequencer #(
      .WORD_W   (WORD_W),
      .NUM_DESC (NUM_DESC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .desc      (desc),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_word   (in_word),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .held_word (held_word),
      .cur_desc  (cur_desc),
      .cur_last  (cur_last)
   );

   slice_extract #(
      .WORD_W  (WORD_W),
      .SLICE_W (SLICE_W)
   ) u_extract (
      .word (held_word),
      .desc (cur_desc),
      .bits (out_bits),
      .cnt  (out_cnt)
   );

   assign out_dir  = cur_desc.dir;
   assign out_last = cur_last;

endmodule

// File: rtl/slice_unpacker_chk.sv
module slice_unpacker_chk #(
   parameter int NUM_DESC = 4,
   parameter int SLICE_W  = 8,
   parameter int CNT_W    = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic               out_valid,
   input logic               out_ready,
   input logic [SLICE_W-1:0] out_bits,
   input logic [CNT_W-1:0]   out_cnt,
   input logic               out_dir,
   input logic               out_last
);

   localparam int SEEN_W = $clog2(NUM_DESC) + 1;
   logic [SEEN_W-1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen <= '0;
      else if (out_valid && out_ready)
         seen <= out_last ? '0 : seen + SEEN_W'(1);
   end

   p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_bits) && $stable(out_cnt)
                                     && $stable(out_dir) && $stable(out_last)));

   p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_cnt >= CNT_W'(1) && out_cnt <= CNT_W'(SLICE_W)));

   p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_bits >> out_cnt) == '0));

   p_accept_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && in_ready) |-> (out_ready && out_last));

   p_bounded_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seen == SEEN_W'(NUM_DESC - 1)) |-> out_last);

endmodule

bind fifo_slice_unpacker slice_unpacker_chk #(
   .NUM_DESC (NUM_DESC),
   .SLICE_W  (SLICE_W),
   .CNT_W    (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_bits  (out_bits),
   .out_cnt   (out_cnt),
   .out_dir   (out_dir),
   .out_last  (out_last)
);

// File: tb/test_fifo_slice_unpacker.sv
`timescale 1ns/1ps
module test_fifo_slice_unpacker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_lo = '0;
   logic [31:0] cfg_hi = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_word = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [7:0]  out_bits;
   logic [3:0]  out_cnt;
   logic        out_dir;
   logic        out_last;

   always #4 clk = ~clk;

   fifo_slice_unpacker i_fifo_slice_unpacker (
      .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
      .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
      .out_valid(out_valid), .out_ready(out_ready), .out_bits(out_bits),
      .out_cnt(out_cnt), .out_dir(out_dir), .out_last(out_last)
   );

   typedef struct {
      logic [7:0] bits;
      int         cnt;
      logic       dir;
      logic       last;
   } slice_t;

   slice_t exp_q[$];
   int     n_tests = 0;
   int     n_fail  = 0;
   int     cycles  = 0;
   bit     mon_on  = 1'b0;
   bit     bp_mode = 1'b0;
   string  cur_req = "R1";
   bit     done    = 1'b0;

   function automatic logic [9:0] mkd(int s, bit d, int l, bit st);
      logic [4:0] s5 = s[4:0];
      logic [2:0] l3 = l[2:0];
      return {s5, d, l3, st};
   endfunction

   // reference model: field layout per R2, extraction per R3 and R4, ending per R7 and R8
   function automatic void model_entry(logic [31:0] w);
      logic [9:0] d;
      for (int v = 0; v < 4; v++) begin
         slice_t s;
         int st, ln, p;
         if (v < 2) d = cfg_lo[v*10 +: 10]; else d = cfg_hi[(v-2)*10 +: 10];
         st = int'(d[9:5]);
         ln = int'(d[3:1]) + 1;
         s.bits = '0;
         for (int k = 0; k < ln; k++) begin
            p = d[4] ? st - k : st + k;
            if (p >= 0 && p < 32) s.bits[k] = w[p];
         end
         s.cnt  = ln;
         s.dir  = d[4];
         s.last = d[0] || (v == 3);
         exp_q.push_back(s);
         if (s.last) break;
      end
   endfunction

   task automatic check(bit ok, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         bit exp_rdy;
         exp_rdy = (exp_q.size() == 0) || (exp_q.size() == 1 && out_ready);
         check(out_valid == (exp_q.size() != 0), "R6 out_valid", out_valid, exp_q.size() != 0);
         check(in_ready == exp_rdy, "R9 in_ready", in_ready, exp_rdy);
         if (out_valid && out_ready && exp_q.size() != 0) begin
            slice_t e;
            e = exp_q.pop_front();
            check(out_bits == e.bits, "R3 R4 bits", out_bits, e.bits);
            check(int'(out_cnt) == e.cnt, "R5 count", out_cnt, e.cnt);
            check(out_dir == e.dir, "R5 dir", out_dir, e.dir);
            check(out_last == e.last, "R7 R8 last", out_last, e.last);
         end
         if (in_valid && in_ready) model_entry(in_word);
      end
   end

   always @(posedge clk) begin
      #1;
      out_ready <= bp_mode ? ($urandom % 3 != 0) : 1'b1;
   end

   task automatic send(logic [31:0] w, int gap);
      in_valid = 1'b1;
      in_word  = w;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
      repeat (gap) @(posedge clk);
      #1;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (exp_q.size() != 0 || out_valid);
      @(posedge clk); #1;
   endtask

   task automatic burst(int n, int gap);
      for (int i = 0; i < n; i++) send($urandom, (gap > 0) ? (i % (gap + 1)) : 0);
      wait_idle();
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, cycles, 150000);
            finish_up();
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
      check(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
      @(posedge clk); #1;
      mon_on = 1'b1;

      // R10 and R2: seven-bit words, four per entry, MSB first
      cur_req = "R10 7x4";
      cfg_lo = {12'h0, mkd(14,1,6,0), mkd(6,1,6,0)};
      cfg_hi = {12'h0, mkd(30,1,6,1), mkd(22,1,6,0)};
      send(32'h7F00_2A55, 0);
      burst(12, 0);

      // R10: fifteen-bit words, two per entry, LSB first
      cur_req = "R10 15x2";
      cfg_lo = {12'h0, mkd(8,0,6,0), mkd(0,0,7,0)};
      cfg_hi = {12'h0, mkd(24,0,6,1), mkd(16,0,7,0)};
      burst(12, 2);

      // R10: one 23-bit word, MSB first, stop on descriptor 2
      cur_req = "R10 23x1";
      cfg_lo = {12'h0, mkd(14,1,7,0), mkd(22,1,7,0)};
      cfg_hi = {12'h0, mkd(0,0,0,0), mkd(6,1,6,1)};
      burst(12, 0);

      // R7: stop on descriptor 1, descriptors 2 and 3 must be ignored
      cur_req = "R7 early stop";
      cfg_lo = {12'h0, mkd(31,1,7,1), mkd(3,0,4,0)};
      cfg_hi = {12'h0, mkd(9,1,2,1), mkd(5,0,7,0)};
      burst(10, 1);

      // R7: stop on descriptor 0 only
      cur_req = "R7 single";
      cfg_lo = {12'h0, mkd(20,0,5,0), mkd(12,1,7,1)};
      burst(8, 0);

      // R8 with R3 and R4 edges: no stop flag, slices run past bit 31 and below bit 0
      cur_req = "R8 no stop";
      cfg_lo = {12'h0, mkd(2,1,7,0), mkd(30,0,7,0)};
      cfg_hi = {12'h0, mkd(0,1,0,0), mkd(31,0,0,0)};
      send(32'hFFFF_FFFF, 0);
      send(32'h8000_0001, 0);
      burst(10, 0);

      // R6 and R9: back-pressure with back-to-back entries
      cur_req = "R6 backpressure 7x4";
      bp_mode = 1'b1;
      cfg_lo = {12'h0, mkd(14,1,6,0), mkd(6,1,6,0)};
      cfg_hi = {12'h0, mkd(30,1,6,1), mkd(22,1,6,0)};
      burst(40, 0);
      cur_req = "R9 backpressure 15x2";
      cfg_lo = {12'h0, mkd(8,0,6,0), mkd(0,0,7,0)};
      cfg_hi = {12'h0, mkd(24,0,6,1), mkd(16,0,7,0)};
      burst(40, 1);
      bp_mode = 1'b0;
      @(posedge clk); #1;

      cur_req = "R1 idle";
      @(negedge clk);
      check(out_valid == 1'b0, "R1 idle out_valid", out_valid, 0);
      check(in_ready == 1'b1, "R1 idle in_ready", in_ready, 1);
      finish_up();
   end

endmodule